// File: doc/BRIEF.md
# Port Pin Interrupt Detector

This block watches an 8-pin port, with inputs that are already synchronized, and raises one interrupt request for the whole port. Each pin gets its own trigger mode: rising edge, falling edge, either edge, high level or low level. A status bit per pin records the trigger condition. An edge-mode status bit stays set until software clears it by writing a 1 to a separate clear address. A level-mode status bit follows the pin's active level.

The request output is the OR, over all pins, of status AND a per-pin mask. The mask is the interrupt enable register in normal operation. While the sleep input is high, a separate wake mask takes its place. Software changes enable bits one pin at a time through a masked write.

Registers are reached through a simple write port and a combinational read port. Address 0 is the trigger register. Address 1 is the enable register. Address 2 is the wake mask. Address 3 reads status, and writes to it are ignored. Address 4 is the write-1-to-clear port and reads 0. Any other read address returns 0.

Top module: `gpio_irq_detect`

## Requirements
- R1: The trigger register holds three bits for pin n: bit n is polarity (1 means high or rising), bit n+8 is edge sensing (1) versus level sensing (0), and bit n+16 selects both edges. A rising-mode pin (value 0x000101 shifted left by n) sets status bit n on a 0-to-1 transition, and the register reads back as written.
- R2: A falling-mode pin (0x000100 shifted by n) sets its status bit on a 1-to-0 transition and not on a 0-to-1 transition.
- R3: A both-edges pin (0x010100 shifted by n) sets its status bit on either transition.
- R4: A level-high pin (0x000001 shifted by n) or level-low pin (0x000000) has a status bit equal to "pin equals polarity", one cycle behind the pin. Writing 1 to its clear bit leaves the status bit set while the level stays active.
- R5: Writing to address 4 clears each edge-mode status bit whose data bit is 1. Data bits that are 0 have no effect.
- R6: If a clear and a new edge event hit the same pin in the same cycle, the status bit stays set.
- R7: irq_o is high exactly when some bit of status AND enable is 1, with sleep low.
- R8: A write to address 1 takes data bits [15:8] as a per-pin mask and data bits [7:0] as new values. Only masked enable bits change.
- R9: While sleep_i is high, the wake mask (address 2) replaces the enable register in forming irq_o.
- R10: Reset (rst_n low at a clock edge) clears trigger, enable, wake, status and the previous-pin sample, so irq_o is low.
- R11: An edge is detected by comparing pin_i with its value sampled at the previous clock edge. The status bit is set at the first clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Synchronized pin levels |
| sleep_i | input | 1 | Selects wake mask instead of enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 24 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 24 | Read data, combinational |
| irq_o | output | 1 | Port interrupt request |

## Verification
If the previous-pin sample or the status register is corrupted, a spurious or missing status bit appears at address 3 one cycle after the pin changes. If the mask is wrong, irq_o disagrees with status in that same cycle. If the clear path or the new-event priority is broken, the status read right after the clearing write shows it: a bit is lost, or it survives when it should not. Level-mode faults appear as a status bit that does not track the pin within one cycle.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int PINS = 8,
  parameter int AW   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PINS-1:0]     pin_i,
  input  logic                sleep_i,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [3*PINS-1:0]   wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [3*PINS-1:0]   rd_data,
  output logic                irq_o
);
  localparam int TW = 3*PINS;
  localparam logic [AW-1:0] A_TRIG = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_WAKE = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_CLR  = AW'(4);

  logic [TW-1:0]   trig_r;
  logic [PINS-1:0] en_r, wake_r, stat_r, pin_q;

  wire [PINS-1:0] pol  = trig_r[PINS-1:0];
  wire [PINS-1:0] edg  = trig_r[2*PINS-1:PINS];
  wire [PINS-1:0] both = trig_r[3*PINS-1:2*PINS];

  wire [PINS-1:0] rise = pin_i & ~pin_q;
  wire [PINS-1:0] fall = ~pin_i & pin_q;
  wire [PINS-1:0] evt  = edg & ((both & (rise | fall)) |
                                (~both & pol & rise) |
                                (~both & ~pol & fall));
  wire [PINS-1:0] lvl  = ~edg & ~(pin_i ^ pol);

  wire wr_trig = wr_en && wr_addr == A_TRIG;
  wire wr_enm  = wr_en && wr_addr == A_EN;
  wire wr_wake = wr_en && wr_addr == A_WAKE;
  wire wr_clr  = wr_en && wr_addr == A_CLR;

  wire [PINS-1:0] clr   = wr_clr ? wr_data[PINS-1:0] : '0;
  wire [PINS-1:0] emask = wr_data[2*PINS-1:PINS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_r <= '0;
      en_r   <= '0;
      wake_r <= '0;
      stat_r <= '0;
      pin_q  <= '0;
    end else begin
      pin_q  <= pin_i;
      stat_r <= lvl | (edg & (evt | (stat_r & ~clr)));
      if (wr_trig) trig_r <= wr_data;
      if (wr_enm)  en_r   <= (en_r & ~emask) | (wr_data[PINS-1:0] & emask);
      if (wr_wake) wake_r <= wr_data[PINS-1:0];
    end
  end

  assign irq_o = |(stat_r & (sleep_i ? wake_r : en_r));

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_TRIG:  rd_data = trig_r;
      A_EN:    rd_data[PINS-1:0] = en_r;
      A_WAKE:  rd_data[PINS-1:0] = wake_r;
      A_STAT:  rd_data[PINS-1:0] = stat_r;
      default: rd_data = '0;
    endcase
  end

  a_r5_clear_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (stat_r & $past(wr_data[PINS-1:0] & edg & ~evt)) == '0);

  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (stat_r & $past(evt)) == $past(evt));

  a_r4_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(!rst_n) && $stable(trig_r)) |->
      ((stat_r ^ ~(pin_q ^ trig_r[PINS-1:0])) & ~trig_r[2*PINS-1:PINS]) == '0);

  a_r8_masked_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enm |=> ((en_r ^ $past(en_r)) & ~$past(wr_data[2*PINS-1:PINS])) == '0);

  a_r7_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && en_r == '0) |-> !irq_o);

  a_r9_no_wake_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && wake_r == '0) |-> !irq_o);
endmodule

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pin_i = '0;
  logic sleep_i = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [23:0] rd_data;
  logic irq_o;
  logic [23:0] tb_trig = '0;
  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gpio_irq_detect u0 (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sleep_i(sleep_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o));

  task automatic chk(input logic [2:0] a, input logic [23:0] exp, input string tag);
    rd_addr = a;
    #1;
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s addr %0d: actual %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #1;
    n_cmp++;
    if (irq_o !== exp) begin
      n_bad++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq_o, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setpins(input logic [7:0] v);
    @(negedge clk);
    pin_i = v;
    @(negedge clk);
  endtask

  task automatic mode(input int p, input logic [2:0] c);
    tb_trig[p] = c[0];
    tb_trig[p+8] = c[1];
    tb_trig[p+16] = c[2];
    wr(3'd0, tb_trig);
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(3'd3, 24'h0, "R10 status");
    chk(3'd0, 24'h0, "R10 trigger");
    chk(3'd1, 24'h0, "R10 enable");
    chk(3'd2, 24'h0, "R10 wake");
    chk_irq(1'b0, "R10");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(3'd3, 24'h0000ff, "R4 level-low after reset");
  endtask

  task automatic t_rise;
    tb_trig = 24'h00ffff;
    wr(3'd0, tb_trig);
    @(negedge clk);
    chk(3'd0, 24'h00ffff, "R1 readback");
    wr(3'd4, 24'hff);
    chk(3'd3, 24'h0, "R5 clear all");
    setpins(8'h01);
    chk(3'd3, 24'h01, "R11 rise one cycle");
    setpins(8'h00);
    chk(3'd3, 24'h01, "R1 fall ignored in rising mode");
    wr(3'd4, 24'h01);
    chk(3'd3, 24'h0, "R5 clear bit0");
  endtask

  task automatic t_clear;
    setpins(8'h06);
    chk(3'd3, 24'h06, "R1 two pins");
    wr(3'd4, 24'h02);
    chk(3'd3, 24'h04, "R5 partial clear");
    wr(3'd4, 24'h00);
    chk(3'd3, 24'h04, "R5 zero write");
    wr(3'd4, 24'hff);
    setpins(8'h00);
    chk(3'd3, 24'h0, "R1 falls ignored");
  endtask

  task automatic t_fall;
    mode(3, 3'b010);
    setpins(8'h08);
    chk(3'd3, 24'h0, "R2 rise ignored");
    setpins(8'h00);
    chk(3'd3, 24'h08, "R2 fall sets");
    wr(3'd4, 24'hff);
  endtask

  task automatic t_both;
    mode(4, 3'b110);
    setpins(8'h10);
    chk(3'd3, 24'h10, "R3 rise");
    wr(3'd4, 24'hff);
    setpins(8'h00);
    chk(3'd3, 24'h10, "R3 fall");
    wr(3'd4, 24'hff);
  endtask

  task automatic t_level;
    mode(5, 3'b001);
    chk(3'd3, 24'h0, "R4 high inactive");
    setpins(8'h20);
    chk(3'd3, 24'h20, "R4 high active");
    wr(3'd4, 24'h20);
    chk(3'd3, 24'h20, "R4 clear no lasting effect");
    setpins(8'h00);
    chk(3'd3, 24'h0, "R4 level released");
    mode(6, 3'b000);
    chk(3'd3, 24'h40, "R4 level low");
    mode(5, 3'b011);
    mode(6, 3'b011);
    wr(3'd4, 24'hff);
    chk(3'd3, 24'h0, "R5 clear after mode change");
  endtask

  task automatic t_race;
    @(negedge clk);
    pin_i = 8'h80; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 24'hff;
    @(negedge clk);
    wr_en = 1'b0;
    chk(3'd3, 24'h80, "R6 event beats clear");
    wr(3'd4, 24'hff);
    setpins(8'h00);
  endtask

  task automatic t_irq;
    setpins(8'h01);
    chk_irq(1'b0, "R7 disabled");
    wr(3'd1, 24'h0101);
    chk(3'd1, 24'h01, "R8 set bit0");
    chk_irq(1'b1, "R7 enabled");
    wr(3'd1, 24'h0200);
    chk(3'd1, 24'h01, "R8 other bit");
    wr(3'd1, 24'h80ff);
    chk(3'd1, 24'h81, "R8 unmasked ignored");
    wr(3'd4, 24'h01);
    chk_irq(1'b0, "R7 status cleared");
  endtask

  task automatic t_sleep;
    setpins(8'h00);
    setpins(8'h01);
    chk_irq(1'b1, "R7 awake");
    sleep_i = 1'b1;
    chk_irq(1'b0, "R9 wake mask empty");
    wr(3'd2, 24'h01);
    chk_irq(1'b1, "R9 wake mask set");
    sleep_i = 1'b0;
    wr(3'd1, 24'h0100);
    chk_irq(1'b0, "R8 enable cleared");
    sleep_i = 1'b1;
    chk_irq(1'b1, "R9 wake replaces enable");
  endtask

  initial begin
    t_reset;
    t_rise;
    t_clear;
    t_fall;
    t_both;
    t_level;
    t_race;
    t_irq;
    t_sleep;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule